// File: doc/BRIEF.md
# Hexagon Motion Search Candidate Sequencer

This block drives the integer-pel candidate search for one 16x16 current macroblock. The search has no early exits. It always runs the same chain of passes: four cross half-scans, one small hexagon, a set of big-hexagon passes, an extended hexagon and a final diamond. Every pass presents up to `NSLOT` candidate positions in parallel, together with a per-slot valid mask. The comparison stage scores the candidates and returns the best motion vector with a one-cycle `best_valid` pulse. That pulse moves the sequencer to the next pass. From the hexagon pass on, every pass is centred on the vector the previous pass returned.

Candidate positions are given as top-left pixel coordinates relative to the search-window origin, so the zero vector lies at `(r, r)`, where `r` is the search range. Every candidate vector is clamped to the square ±r before it is converted. For each candidate the block also gives the x addresses of the four 4x4 sub-blocks in its top row and the y addresses of the four 4x4 sub-blocks in its left column. Together with the candidate's own x and y, these give the top-left pixel of each of those sub-blocks.

The controller has three states. IDLE goes to PASS on `start`. PASS stays in PASS while `best_valid` is low, moves to the next pass on `best_valid`, and goes to DONE on the `best_valid` of the last pass. DONE goes to IDLE after one cycle.

Top module: `fms_addr_seq`

## Requirements
- R1: After reset the block is idle: `pass_idx` is 0, `done` is 0 and `cand_valid` is all zero.
- R2: A `start` in IDLE makes `pass_idx` equal 1 on the next cycle. The centre then starts at (0,0). A `start` received while a search runs is ignored, and `pass_idx` and the later candidates are unchanged.
- R3: Passes are numbered from 1 in this order: passes 1 and 2 are the left and right cross scans, passes 3 and 4 are the up and down cross scans, pass 5 is the hexagon, passes 6 to 5+2q are the big hexagons, pass 6+2q is the extended hexagon and pass 7+2q is the diamond, where q = r/4. `pass_idx` changes only on a cycle after `best_valid`.
- R4: The cross passes are centred on (0,0). Slot k carries offset -2(k+1) or +2(k+1) along its axis (left and up are negative), and slots k < 2q are valid.
- R5: The hexagon and extended-hexagon passes use offsets (2,0), (-2,0), (1,2), (-1,2), (1,-2), (-1,-2) in slots 0 to 5.
- R6: Big-hexagon pass 6+j uses ring h = j/2+1 and pattern entries 8*(j mod 2)+k in slots k = 0..7. The pattern, in index order, is (4,0), (-4,0), (0,4), (0,-4), (4,1), (4,-1), (-4,1), (-4,-1), (4,2), (4,-2), (-4,2), (-4,-2), (2,3), (2,-3), (-2,3), (-2,-3), and each entry is multiplied by h.
- R7: The diamond pass uses offsets (1,0), (-1,0), (0,1), (0,-1) in slots 0 to 3.
- R8: Passes 5 and later add their offsets to the best vector returned by the previous pass.
- R9: Each component of a candidate vector is clamped to [-r, r]. The output coordinate is the clamped component plus r.
- R10: For a valid slot, the top-row sub-block x addresses are x+4i and the left-column sub-block y addresses are y+4i, for i = 0..3.
- R11: Slots beyond a pass's point count are invalid, and `cand_valid` is zero outside PASS. The coordinates of invalid slots carry no meaning.
- R12: `done` is high for exactly one cycle, the cycle after the last pass's `best_valid`, and the block is idle on the cycle after that.
- R13: `range_q` gives q and is latched at `start`. A value of 0 is treated as 1, and a value above `SMAX/4` is treated as `SMAX/4`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search for one macroblock |
| range_q | input | QW | Search range in units of 4 pixels (q) |
| best_valid | input | 1 | Comparison stage has returned the best vector of the current pass |
| best_mvx | input | MVW | Best vector x, signed |
| best_mvy | input | MVW | Best vector y, signed |
| cand_x | output | NSLOT*CW | Candidate top-left x per slot |
| cand_y | output | NSLOT*CW | Candidate top-left y per slot |
| cand_valid | output | NSLOT | Per-slot valid mask |
| row_x | output | NSLOT*4*AW | Top-row 4x4 sub-block x addresses, slot-major |
| col_y | output | NSLOT*4*AW | Left-column 4x4 sub-block y addresses, slot-major |
| pass_idx | output | PW | Current pass number, 0 when not in PASS |
| done | output | 1 | One-cycle end-of-search pulse |

## Verification
The bench runs every search range from q=1 to q=4, plus the two saturating codes, and checks every slot of every pass against an offset model computed in the bench. It returns best vectors that pull the centre to the window edge, so that the hexagon and big-hexagon rings go outside the window. A design that skipped or misplaced the clamp, or that ignored the returned vector when re-centring, would produce out-of-window or wrongly centred coordinates. A design that counted big-hexagon halves wrongly would give the wrong number of passes for a given q, or scale rings by the wrong factor. The bench also sends `start` in the middle of a search and leaves gaps in the handshake. A design that restarted on that `start` or advanced without `best_valid` would show the wrong pass number.

// File: rtl/fms_pkg.sv
package fms_pkg;

    typedef enum logic [2:0] {
        PK_NONE, PK_LEFT, PK_RIGHT, PK_UP, PK_DOWN, PK_HEX, PK_BIG, PK_DIA
    } pass_kind_e;

    // six-point hexagon, slot order fixed
    function automatic int hex_dx(input int i);
        case (i)
            0: return 2;
            1: return -2;
            2, 4: return 1;
            default: return -1;
        endcase
    endfunction

    function automatic int hex_dy(input int i);
        case (i)
            0, 1: return 0;
            2, 3: return 2;
            default: return -2;
        endcase
    endfunction

    // sixteen-point big hexagon at unit scale
    function automatic int big_dx(input int i);
        case (i)
            0, 4, 5, 8, 9: return 4;
            1, 6, 7, 10, 11: return -4;
            2, 3: return 0;
            12, 13: return 2;
            default: return -2;
        endcase
    endfunction

    function automatic int big_dy(input int i);
        case (i)
            0, 1: return 0;
            2: return 4;
            3: return -4;
            4, 6: return 1;
            5, 7: return -1;
            8, 10: return 2;
            9, 11: return -2;
            12, 14: return 3;
            default: return -3;
        endcase
    endfunction

    function automatic int dia_dx(input int i);
        case (i)
            0: return 1;
            1: return -1;
            default: return 0;
        endcase
    endfunction

    function automatic int dia_dy(input int i);
        case (i)
            2: return 1;
            3: return -1;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/fms_seq.sv
module fms_seq
    import fms_pkg::*;
#(
    parameter int SMAX = 16,
    localparam int QMAX = SMAX / 4,
    localparam int QW   = $clog2(QMAX + 1),
    localparam int MVW  = $clog2(SMAX) + 2,
    localparam int PMAX = 7 + 2 * QMAX,
    localparam int PW   = $clog2(PMAX + 1),
    localparam int HW   = $clog2(QMAX + 1),
    localparam int RW   = $clog2(SMAX + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [QW-1:0]         range_q,
    input  logic                  best_valid,
    input  logic signed [MVW-1:0] best_mvx,
    input  logic signed [MVW-1:0] best_mvy,
    output pass_kind_e            kind,
    output logic [HW-1:0]         ring,
    output logic                  half,
    output logic [RW-1:0]         rad,
    output logic signed [MVW-1:0] cx,
    output logic signed [MVW-1:0] cy,
    output logic [PW-1:0]         pass_idx,
    output logic                  done
);

    typedef enum logic [1:0] {S_IDLE, S_PASS, S_DONE} state_e;

    state_e               state, state_n;
    logic [PW-1:0]        pidx, pidx_n;
    logic [QW-1:0]        q_r, q_n;
    logic signed [MVW-1:0] cx_r, cx_n, cy_r, cy_n;
    int                   lastp;

    assign lastp = 7 + 2 * int'(q_r);

    // next-state logic
    always_comb begin
        state_n = state;
        pidx_n  = pidx;
        q_n     = q_r;
        cx_n    = cx_r;
        cy_n    = cy_r;
        unique case (state)
            S_IDLE: if (start) begin
                state_n = S_PASS;
                pidx_n  = PW'(1);
                cx_n    = '0;
                cy_n    = '0;
                if (range_q == '0)                 q_n = QW'(1);
                else if (int'(range_q) > QMAX)     q_n = QW'(QMAX);
                else                               q_n = range_q;
            end
            S_PASS: if (best_valid) begin
                cx_n = best_mvx;
                cy_n = best_mvy;
                if (int'(pidx) == lastp) begin
                    state_n = S_DONE;
                    pidx_n  = '0;
                end else begin
                    pidx_n = pidx + PW'(1);
                end
            end
            S_DONE: state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            pidx  <= '0;
            q_r   <= QW'(1);
            cx_r  <= '0;
            cy_r  <= '0;
        end else begin
            state <= state_n;
            pidx  <= pidx_n;
            q_r   <= q_n;
            cx_r  <= cx_n;
            cy_r  <= cy_n;
        end
    end

    // outputs
    always_comb begin
        int p;
        int k;
        p    = int'(pidx);
        k    = (p >= 6) ? p - 6 : 0;
        kind = PK_NONE;
        if (state == S_PASS) begin
            if (p == 1)                     kind = PK_LEFT;
            else if (p == 2)                kind = PK_RIGHT;
            else if (p == 3)                kind = PK_UP;
            else if (p == 4)                kind = PK_DOWN;
            else if (p == 5)                kind = PK_HEX;
            else if (p <= 5 + 2 * int'(q_r)) kind = PK_BIG;
            else if (p == 6 + 2 * int'(q_r)) kind = PK_HEX;
            else                            kind = PK_DIA;
        end
        ring     = HW'(k / 2 + 1);
        half     = (k % 2) == 1;
        rad      = RW'(4 * int'(q_r));
        cx       = cx_r;
        cy       = cy_r;
        pass_idx = pidx;
        done     = (state == S_DONE);
    end

    a_r2_start_launches: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start) |=> (pass_idx == PW'(1)));
    a_r3_hold_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PASS && !best_valid) |=> $stable(pass_idx));
    a_r3_pass_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pass_idx) <= lastp);
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && pass_idx == '0));
    a_r13_range_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PASS) |-> (q_r != '0 && int'(q_r) <= QMAX));

endmodule

// File: rtl/fms_slot.sv
module fms_slot
    import fms_pkg::*;
#(
    parameter int SMAX = 16,
    parameter int SLOT = 0,
    localparam int QMAX = SMAX / 4,
    localparam int MVW  = $clog2(SMAX) + 2,
    localparam int HW   = $clog2(QMAX + 1),
    localparam int RW   = $clog2(SMAX + 1),
    localparam int CW   = $clog2(2 * SMAX + 1),
    localparam int AW   = $clog2(2 * SMAX + 13)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  pass_kind_e            kind,
    input  logic [HW-1:0]         ring,
    input  logic                  half,
    input  logic [RW-1:0]         rad,
    input  logic signed [MVW-1:0] cx,
    input  logic signed [MVW-1:0] cy,
    output logic                  valid,
    output logic [CW-1:0]         x,
    output logic [CW-1:0]         y,
    output logic [4*AW-1:0]       row_x,
    output logic [4*AW-1:0]       col_y
);

    int   ri, hi, dx, dy, sx, sy, xi, yi, idx;
    logic use_ctr;

    always_comb begin
        ri      = int'(rad);
        hi      = int'(ring);
        idx     = int'(half) * 8 + (SLOT % 8);
        valid   = 1'b0;
        dx      = 0;
        dy      = 0;
        use_ctr = 1'b1;
        unique case (kind)
            PK_LEFT:  begin valid = (SLOT < ri / 2); dx = -2 * (SLOT + 1); use_ctr = 1'b0; end
            PK_RIGHT: begin valid = (SLOT < ri / 2); dx =  2 * (SLOT + 1); use_ctr = 1'b0; end
            PK_UP:    begin valid = (SLOT < ri / 2); dy = -2 * (SLOT + 1); use_ctr = 1'b0; end
            PK_DOWN:  begin valid = (SLOT < ri / 2); dy =  2 * (SLOT + 1); use_ctr = 1'b0; end
            PK_HEX:   begin valid = (SLOT < 6); dx = hex_dx(SLOT % 6); dy = hex_dy(SLOT % 6); end
            PK_BIG:   begin valid = (SLOT < 8); dx = big_dx(idx) * hi; dy = big_dy(idx) * hi; end
            PK_DIA:   begin valid = (SLOT < 4); dx = dia_dx(SLOT % 4); dy = dia_dy(SLOT % 4); end
            default:  valid = 1'b0;
        endcase
        sx = (use_ctr ? int'(cx) : 0) + dx;
        sy = (use_ctr ? int'(cy) : 0) + dy;
        if (sx > ri)  sx = ri;
        if (sx < -ri) sx = -ri;
        if (sy > ri)  sy = ri;
        if (sy < -ri) sy = -ri;
        xi = sx + ri;
        yi = sy + ri;
        x  = CW'(xi);
        y  = CW'(yi);
        for (int i = 0; i < 4; i++) begin
            row_x[i*AW +: AW] = AW'(xi + 4 * i);
            col_y[i*AW +: AW] = AW'(yi + 4 * i);
        end
    end

    a_r9_inside_window: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (int'(x) <= 2 * int'(rad) && int'(y) <= 2 * int'(rad)));

endmodule

// File: rtl/fms_addr_seq.sv
module fms_addr_seq
    import fms_pkg::*;
#(
    parameter int SMAX  = 16,
    parameter int NSLOT = 8,
    localparam int QMAX = SMAX / 4,
    localparam int QW   = $clog2(QMAX + 1),
    localparam int MVW  = $clog2(SMAX) + 2,
    localparam int PMAX = 7 + 2 * QMAX,
    localparam int PW   = $clog2(PMAX + 1),
    localparam int CW   = $clog2(2 * SMAX + 1),
    localparam int AW   = $clog2(2 * SMAX + 13)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [QW-1:0]           range_q,
    input  logic                    best_valid,
    input  logic signed [MVW-1:0]   best_mvx,
    input  logic signed [MVW-1:0]   best_mvy,
    output logic [NSLOT*CW-1:0]     cand_x,
    output logic [NSLOT*CW-1:0]     cand_y,
    output logic [NSLOT-1:0]        cand_valid,
    output logic [NSLOT*4*AW-1:0]   row_x,
    output logic [NSLOT*4*AW-1:0]   col_y,
    output logic [PW-1:0]           pass_idx,
    output logic                    done
);

    localparam int HW = $clog2(QMAX + 1);
    localparam int RW = $clog2(SMAX + 1);

    pass_kind_e            kind;
    logic [HW-1:0]         ring;
    logic                  half;
    logic [RW-1:0]         rad;
    logic signed [MVW-1:0] cx, cy;

    fms_seq #(.SMAX(SMAX)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .range_q(range_q),
        .best_valid(best_valid), .best_mvx(best_mvx), .best_mvy(best_mvy),
        .kind(kind), .ring(ring), .half(half), .rad(rad), .cx(cx), .cy(cy),
        .pass_idx(pass_idx), .done(done)
    );

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        fms_slot #(.SMAX(SMAX), .SLOT(s)) u_slot (
            .clk(clk), .rst_n(rst_n), .kind(kind), .ring(ring), .half(half),
            .rad(rad), .cx(cx), .cy(cy),
            .valid(cand_valid[s]),
            .x(cand_x[s*CW +: CW]), .y(cand_y[s*CW +: CW]),
            .row_x(row_x[s*4*AW +: 4*AW]), .col_y(col_y[s*4*AW +: 4*AW])
        );
    end

    initial begin
        assert (NSLOT >= 8 && NSLOT >= SMAX / 2 && SMAX % 4 == 0)
            else $error("slot count or range parameter unsupported");
    end

    a_r11_idle_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_idx == '0) |-> (cand_valid == '0));

endmodule

// File: tb/tb_fms_addr_seq.sv
`timescale 1ns/1ps
module tb_fms_addr_seq;

    localparam int SMAX = 16;
    localparam int NSLOT = 8;
    localparam int QMAX = SMAX / 4;
    localparam int QW = $clog2(QMAX + 1);
    localparam int MVW = $clog2(SMAX) + 2;
    localparam int PW = $clog2(7 + 2 * QMAX + 1);
    localparam int CW = $clog2(2 * SMAX + 1);
    localparam int AW = $clog2(2 * SMAX + 13);

    logic clk = 0, rst_n = 0, start = 0, best_valid = 0;
    logic [QW-1:0] range_q = '0;
    logic signed [MVW-1:0] best_mvx = '0, best_mvy = '0;
    logic [NSLOT*CW-1:0] cand_x, cand_y;
    logic [NSLOT-1:0] cand_valid;
    logic [NSLOT*4*AW-1:0] row_x, col_y;
    logic [PW-1:0] pass_idx;
    logic done;

    int checks = 0, fails = 0;

    fms_addr_seq #(.SMAX(SMAX), .NSLOT(NSLOT)) dut (.*);

    always #4 clk = ~clk;

    int hx[6] = '{2, -2, 1, -1, 1, -1};
    int hy[6] = '{0, 0, 2, 2, -2, -2};
    int bx[16] = '{4, -4, 0, 0, 4, 4, -4, -4, 4, 4, -4, -4, 2, 2, -2, -2};
    int by[16] = '{0, 0, 4, -4, 1, -1, 1, -1, 2, -2, 2, -2, 3, -3, 3, -3};
    int ddx[4] = '{1, -1, 0, 0};
    int ddy[4] = '{0, 0, 1, -1};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void model(input int p, input int q, input int s, input int cx, input int cy,
                                  output bit v, output int mx, output int my, output string tag);
        int r = 4 * q, dx = 0, dy = 0, ux, uy;
        bit ctr = 1;
        v = 0;
        if (p <= 4) begin
            ctr = 0; v = (s < 2 * q); tag = "R4";
            case (p)
                1: dx = -2 * (s + 1);
                2: dx = 2 * (s + 1);
                3: dy = -2 * (s + 1);
                default: dy = 2 * (s + 1);
            endcase
        end else if (p == 5 || p == 6 + 2 * q) begin
            v = (s < 6); tag = "R5 R8";
            if (v) begin dx = hx[s]; dy = hy[s]; end
        end else if (p <= 5 + 2 * q) begin
            int j = p - 6;
            v = (s < 8); tag = "R6 R8";
            if (v) begin
                dx = bx[8 * (j % 2) + s] * (j / 2 + 1);
                dy = by[8 * (j % 2) + s] * (j / 2 + 1);
            end
        end else begin
            v = (s < 4); tag = "R7 R8";
            if (v) begin dx = ddx[s]; dy = ddy[s]; end
        end
        ux = (ctr ? cx : 0) + dx;
        uy = (ctr ? cy : 0) + dy;
        mx = ux > r ? r : (ux < -r ? -r : ux);
        my = uy > r ? r : (uy < -r ? -r : uy);
        if (mx != ux || my != uy) tag = {tag, " R9"};
    endfunction

    task automatic run_seq(input int rq);
        int q = rq < 1 ? 1 : (rq > QMAX ? QMAX : rq);
        int r = 4 * q;
        int last = 7 + 2 * q;
        int ecx = 0, ecy = 0;
        @(negedge clk);
        start = 1; range_q = QW'(rq);
        @(negedge clk);
        start = 0;
        for (int p = 1; p <= last; p++) begin
            int selx = 0, sely = 0, nv = 0;
            chk(int'(pass_idx) == p, "R3 pass index", int'(pass_idx), p);
            chk(done == 1'b0, "R12 done low in pass", int'(done), 0);
            if (p == 1)
                chk($countones(cand_valid) == 2 * q, "R13 range latched", $countones(cand_valid), 2 * q);
            for (int s = 0; s < NSLOT; s++) begin
                bit v; int mx, my; string tag;
                model(p, q, s, ecx, ecy, v, mx, my, tag);
                chk(cand_valid[s] == v, {tag, " R11 slot valid"}, int'(cand_valid[s]), int'(v));
                if (v) begin
                    chk(int'(cand_x[s*CW +: CW]) == mx + r, {tag, " x"}, int'(cand_x[s*CW +: CW]), mx + r);
                    chk(int'(cand_y[s*CW +: CW]) == my + r, {tag, " y"}, int'(cand_y[s*CW +: CW]), my + r);
                    for (int i = 0; i < 4; i++) begin
                        chk(int'(row_x[(s*4+i)*AW +: AW]) == mx + r + 4 * i, "R10 row x",
                            int'(row_x[(s*4+i)*AW +: AW]), mx + r + 4 * i);
                        chk(int'(col_y[(s*4+i)*AW +: AW]) == my + r + 4 * i, "R10 col y",
                            int'(col_y[(s*4+i)*AW +: AW]), my + r + 4 * i);
                    end
                    if (nv == (p * 3) % ((p <= 4) ? 2 * q : (p == 5 || p == 6 + 2 * q) ? 6 :
                                         (p == last) ? 4 : 8)) begin
                        selx = mx; sely = my;
                    end
                    nv++;
                end
            end
            if (p % 2 == 1) begin
                start = 1;
                @(negedge clk);
                start = 0;
                chk(int'(pass_idx) == p, "R2 start ignored while busy", int'(pass_idx), p);
                chk(int'(pass_idx) == p, "R3 no advance without ack", int'(pass_idx), p);
            end
            best_valid = 1; best_mvx = MVW'(selx); best_mvy = MVW'(sely);
            ecx = selx; ecy = sely;
            @(negedge clk);
            best_valid = 0;
        end
        chk(done == 1'b1, "R12 done after last pass", int'(done), 1);
        chk(cand_valid == '0, "R11 mask zero in done", int'(cand_valid), 0);
        chk(pass_idx == '0, "R3 pass index cleared", int'(pass_idx), 0);
        @(negedge clk);
        chk(done == 1'b0, "R12 done single cycle", int'(done), 0);
        chk(cand_valid == '0, "R11 mask zero in idle", int'(cand_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(pass_idx == '0, "R1 reset pass index", int'(pass_idx), 0);
        chk(done == 1'b0, "R1 reset done", int'(done), 0);
        chk(cand_valid == '0, "R1 reset mask", int'(cand_valid), 0);
        for (int rq = 1; rq <= QMAX; rq++) run_seq(rq);
        run_seq(0);
        run_seq((1 << QW) - 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule